// File: doc/BRIEF.md
# Dual-Clock FIFO with Output-Ready Prefetch

This block carries 32-bit words from a producer clocked by `wr_clk` to a consumer clocked by an unrelated `rd_clk`. Its default configuration has 512 words of storage. The producer pushes words while `in_ready` is high. The consumer does not request the first word. As soon as a word reaches the read side, it is moved into a dedicated output register, and `out_ready` rises on the same read-clock edge. The word is therefore already on `rd_data` when `out_ready` is seen high. After that, a new word is loaded only when the consumer selects a read with `rd_en`.

The two sides exchange pointer positions as Gray code through a chain of at least two flip-flops in the receiving clock domain. Each side works from a copy of the other side's position that is delayed and therefore pessimistic. The write side reports an almost-full level on `almost_full`, and the read side reports an almost-empty level on `almost_empty`. Both offsets are parameters.

Top module: `xclk_fifo`

## Requirements
- R1: When both resets are released, `in_ready` is 1, `out_ready` is 0, `almost_full` is 0 and `almost_empty` is 1.
- R2: If `out_ready` is low and a word is present in storage, the next `rd_clk` rising edge sets `out_ready` high and puts the oldest word on `rd_data`. No `rd_en` is needed for this.
- R3: While `out_ready` is high, `out_ready` and `rd_data` change only on a `rd_clk` edge where `rd_en` is high.
- R4: Words leave the FIFO in the order they were written, with their values unchanged, across many different write and read patterns.
- R5: A word is accepted only on a `wr_clk` edge where both `wr_en` and `in_ready` are high. Writes attempted while `in_ready` is low are discarded and never show up at the read side.
- R6: A `rd_en` pulse while `out_ready` is low is ignored. A word written later is still delivered intact.
- R7: The FIFO holds DEPTH words in storage plus one word in the output register. `in_ready` goes low once storage holds DEPTH words, and it rises again after reads free space.
- R8: `almost_full` is high exactly when the storage occupancy seen from the write side is at least DEPTH − AF_OFFSET. The output register is not counted in this occupancy.
- R9: `almost_empty` is high exactly when the number of words readable from the read side, storage plus the output register, is at most AE_OFFSET.
- R10: A write reaches the read side only through at least two `rd_clk` synchronizer stages. `out_ready` therefore stays low for at least the first two `rd_clk` rising edges after the write that makes the FIFO non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| in_ready | output | 1 | Storage can accept a word |
| almost_full | output | 1 | Write-side occupancy at or above threshold |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read request, consumes the word in the output register |
| rd_data | output | DATA_W | Output register |
| out_ready | output | 1 | `rd_data` holds a valid word |
| almost_empty | output | 1 | Readable count at or below threshold |

## Verification
The in-module assertions check five properties on every clock cycle. Neither pointer ever runs past the other. A blocked write leaves the write pointer unchanged. Each Gray pointer changes by at most one bit per edge. The output register holds while `out_ready` is high and no read is selected. An idle output register preloads on the edge after data becomes visible.

Some behaviours can only be shown by the bench scenarios. These are the end-to-end word ordering, the exact capacity of DEPTH plus one, the flag thresholds at every fill level, the loss of writes attempted while full, and the delay through the synchronizers. The bench shows them by filling and draining a small FIFO one word at a time and by running concurrent traffic.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xfifo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 512,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
   import xfifo_pkg::*;
#(
   parameter int DEPTH     = 512,
   parameter int AF_OFFSET = 8,
   parameter int ADDR_W    = 9,
   parameter int PTR_W     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  rd_gray_s,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PTR_W-1:0]  wr_gray,
   output logic              push,
   output logic              in_ready,
   output logic              almost_full
);
   localparam logic [PTR_W-1:0] DEPTH_P  = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] AF_LEVEL = PTR_W'(DEPTH - AF_OFFSET);

   logic [PTR_W-1:0] wr_bin;
   logic [PTR_W-1:0] wr_bin_nx;
   logic [PTR_W-1:0] rd_bin_s;
   logic [PTR_W-1:0] level;

   assign rd_bin_s    = PTR_W'(gray_to_bin(32'(rd_gray_s)));
   assign level       = wr_bin - rd_bin_s;
   assign in_ready    = (level != DEPTH_P);
   assign push        = wr_en & in_ready;
   assign almost_full = (level >= AF_LEVEL);
   assign wr_addr     = wr_bin[ADDR_W-1:0];
   assign wr_bin_nx   = wr_bin + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (push) begin
         wr_bin  <= wr_bin_nx;
         wr_gray <= PTR_W'(bin_to_gray(32'(wr_bin_nx)));
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) level <= DEPTH_P); // R7
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !in_ready) |=> $stable(wr_bin)); // R5
   AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(wr_gray ^ $past(wr_gray)) <= 1); // R10
endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
   import xfifo_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 512,
   parameter int AE_OFFSET = 8,
   parameter int ADDR_W    = 9,
   parameter int PTR_W     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  wr_gray_s,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [PTR_W-1:0]  rd_gray,
   output logic [DATA_W-1:0] dout,
   output logic              out_ready,
   output logic              almost_empty
);
   localparam int               CNT_W    = PTR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH_P  = PTR_W'(DEPTH);
   localparam logic [CNT_W-1:0] AE_LEVEL = CNT_W'(AE_OFFSET);

   logic [PTR_W-1:0] rd_bin;
   logic [PTR_W-1:0] rd_bin_nx;
   logic [PTR_W-1:0] wr_bin_s;
   logic [PTR_W-1:0] stored;
   logic [CNT_W-1:0] readable;
   logic             avail;
   logic             pop;
   logic             load;

   assign wr_bin_s     = PTR_W'(gray_to_bin(32'(wr_gray_s)));
   assign stored       = wr_bin_s - rd_bin;
   assign avail        = (stored != '0);
   assign pop          = rd_en & out_ready;
   assign load         = avail & (~out_ready | rd_en);
   assign rd_addr      = rd_bin[ADDR_W-1:0];
   assign rd_bin_nx    = rd_bin + 1'b1;
   assign readable     = CNT_W'(stored) + CNT_W'(out_ready);
   assign almost_empty = (readable <= AE_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin    <= '0;
         rd_gray   <= '0;
         dout      <= '0;
         out_ready <= 1'b0;
      end else if (load) begin
         rd_bin    <= rd_bin_nx;
         rd_gray   <= PTR_W'(bin_to_gray(32'(rd_bin_nx)));
         dout      <= mem_rdata;
         out_ready <= 1'b1;
      end else if (pop) begin
         out_ready <= 1'b0;
      end
   end

   AST_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n) (!out_ready && avail) |=> (out_ready && dout == $past(mem_rdata))); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_ready && !rd_en) |=> (out_ready && $stable(dout))); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) stored <= DEPTH_P); // R6
   AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(rd_gray ^ $past(rd_gray)) <= 1); // R10
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 512,
   parameter int AF_OFFSET   = 8,
   parameter int AE_OFFSET   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              in_ready,
   output logic              almost_full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_ready,
   output logic              almost_empty
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PTR_W  = ADDR_W + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("xclk_fifo: DEPTH must be a power of two, at least 4");
   end
   if (PTR_W > 32) begin : g_bad_ptr
      $error("xclk_fifo: pointer wider than 32 bits");
   end
   if (AF_OFFSET < 0 || AF_OFFSET >= DEPTH) begin : g_bad_af
      $error("xclk_fifo: AF_OFFSET out of range");
   end
   if (AE_OFFSET < 0 || AE_OFFSET >= DEPTH) begin : g_bad_ae
      $error("xclk_fifo: AE_OFFSET out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xclk_fifo: SYNC_STAGES must be at least 2");
   end

   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [PTR_W-1:0]  wr_gray;
   logic [PTR_W-1:0]  rd_gray;
   logic [PTR_W-1:0]  wr_gray_s;
   logic [PTR_W-1:0]  rd_gray_s;
   logic [DATA_W-1:0] mem_rdata;
   logic              push;

   xfifo_wr_ctrl #(
      .DEPTH(DEPTH), .AF_OFFSET(AF_OFFSET), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
   ) u_wr_ctrl (
      .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
      .wr_addr(wr_addr), .wr_gray(wr_gray), .push(push),
      .in_ready(in_ready), .almost_full(almost_full)
   );

   xfifo_mem #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
   ) u_mem (
      .clk(wr_clk), .we(push), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_addr), .rdata(mem_rdata)
   );

   xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
   );

   xfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
   );

   xfifo_rd_ctrl #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .AE_OFFSET(AE_OFFSET),
      .ADDR_W(ADDR_W), .PTR_W(PTR_W)
   ) u_rd_ctrl (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
      .mem_rdata(mem_rdata), .rd_addr(rd_addr), .rd_gray(rd_gray),
      .dout(rd_data), .out_ready(out_ready), .almost_empty(almost_empty)
   );
endmodule

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = 12;
   localparam int DW         = 32;
   localparam int DEPTH      = 16;
   localparam int AF_OFF     = 3;
   localparam int AE_OFF     = 2;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_rst_n = 1'b0;
   logic          rd_rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          in_ready, almost_full, out_ready, almost_empty;

   int checks = 0;
   int failures = 0;

   xclk_fifo #(
      .DATA_W(DW), .DEPTH(DEPTH), .AF_OFFSET(AF_OFF), .AE_OFFSET(AE_OFF), .SYNC_STAGES(2)
   ) u_xclk_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .in_ready(in_ready), .almost_full(almost_full),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
      .out_ready(out_ready), .almost_empty(almost_empty)
   );

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   initial begin
      #2;
      forever #(RD_PERIOD/2) rd_clk = ~rd_clk;
   end

   function automatic logic [DW-1:0] pat(input int i);
      return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (10) @(negedge rd_clk);
   endtask

   task automatic write_word(input logic [DW-1:0] d);
      @(negedge wr_clk);
      while (!in_ready) @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic read_word(output logic [DW-1:0] d);
      @(negedge rd_clk);
      while (!out_ready) @(negedge rd_clk);
      d = rd_data;
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
   endtask

   task automatic check_flags(input string tag, input int n);
      int mem_words;
      mem_words = (n == 0) ? 0 : n - 1;
      chk({tag, " R8 almost_full"}, 32'(almost_full), 32'(mem_words >= DEPTH - AF_OFF));
      chk({tag, " R9 almost_empty"}, 32'(almost_empty), 32'(n <= AE_OFF));
      chk({tag, " R7 in_ready"}, 32'(in_ready), 32'(mem_words < DEPTH));
      chk({tag, " R2 out_ready"}, 32'(out_ready), 32'(n > 0));
   endtask

   initial begin
      logic [DW-1:0] got;
      int rcv;
      repeat (4) @(negedge wr_clk);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      repeat (2) @(negedge rd_clk);
      // R1 reset state
      chk("R1 in_ready", 32'(in_ready), 32'd1);
      chk("R1 out_ready", 32'(out_ready), 32'd0);
      chk("R1 almost_full", 32'(almost_full), 32'd0);
      chk("R1 almost_empty", 32'(almost_empty), 32'd1);

      // R10: first write, out_ready low through two rd_clk edges
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = pat(0);
      @(posedge wr_clk);
      wr_en <= #2 1'b0;
      @(posedge rd_clk);
      @(posedge rd_clk);
      #1;
      chk("R10 out_ready after two rd edges", 32'(out_ready), 32'd0);
      settle();
      chk("R2 prefetched word", rd_data, pat(0));
      check_flags("fill n=1", 1);

      // fill one word at a time, no reads: R3 holds head
      for (int n = 2; n <= DEPTH + 1; n++) begin
         write_word(pat(n - 1));
         settle();
         check_flags("fill", n);
         chk("R3 head held without rd_en", rd_data, pat(0));
      end

      // R5: writes while full are dropped
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = 32'hDEAD_BEEF;
      repeat (4) @(negedge wr_clk);
      wr_en = 1'b0;
      settle();
      chk("R5 in_ready stays low", 32'(in_ready), 32'd0);

      // drain one at a time
      for (int k = 0; k <= DEPTH; k++) begin
         read_word(got);
         chk("R4 drain order", got, pat(k));
         settle();
         check_flags("drain", DEPTH - k);
      end
      chk("R5 no dropped word appeared", 32'(out_ready), 32'd0);

      // R6: reads while empty ignored
      @(negedge rd_clk);
      rd_en = 1'b1;
      repeat (3) @(negedge rd_clk);
      rd_en = 1'b0;
      settle();
      chk("R6 out_ready after empty reads", 32'(out_ready), 32'd0);
      write_word(pat(500));
      settle();
      chk("R6 out_ready after late write", 32'(out_ready), 32'd1);
      chk("R6 late word intact", rd_data, pat(500));
      read_word(got);
      settle();
      chk("R6 empty again", 32'(out_ready), 32'd0);

      // R4 concurrent traffic
      rcv = 0;
      fork
         begin
            for (int i = 0; i < 60; i++) write_word(pat(1000 + i));
         end
         begin
            for (int i = 0; i < 60; i++) begin
               if (i % 3 == 0) repeat (5) @(negedge rd_clk);
               read_word(got);
               chk("R4 streaming order", got, pat(1000 + i));
               rcv++;
            end
         end
      join
      chk("R4 streaming count", 32'(rcv), 32'd60);
      settle();
      chk("R7 in_ready after stream", 32'(in_ready), 32'd1);
      chk("R9 almost_empty after stream", 32'(almost_empty), 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule